// File: doc/BRIEF.md
# Execute-Stage Exception Detector and Vector Selector

This unit sits next to the execute stage of a small processor. Each cycle in which an instruction is presented, it evaluates that instruction's fault conditions. These cover divide status, the overflow trap instruction, the array bounds check, floating-point use without a coprocessor, stack-limit violations and operand alignment. Externally detected faults arrive as plain pins: an undefined opcode, a segment that is not present, a protection violation and a page miss. The unit turns whatever is true into one exception request carrying an 8-bit vector number and, where the vector defines one, an error code.

The request is registered and held until the handler side acknowledges it. The unit then counts as delivering an exception until the handler signals completion. A new fault raised during that window is escalated to the double-fault vector. A fault raised while a double fault is itself being delivered drives a sticky shutdown output, and no further vector is raised. Vector 2 belongs to the external non-maskable interrupt, so no internal condition ever produces it.

Top module: `exc_unit`

## Requirements
- R1: With `instr_vld_i` high, `div_zero_i` or `div_ovf_i` raises vector 0 with `exc_has_err_o`=0, one cycle later.
- R2: `into_i` with `of_flag_i`=1 raises vector 4. `into_i` with `of_flag_i`=0 raises nothing.
- R3: With `bound_i` high, a signed `bound_idx_i` below `bound_lo_i` or above `bound_hi_i` raises vector 5. An index equal to either limit raises nothing.
- R4: `fp_op_i` raises vector 7 only when `fp_emul_i`=1 and `fpu_present_i`=0.
- R5: `stk_lim_i` raises vector 12 with error code 0 and `exc_has_err_o`=1. The fault pins `bad_op_i`, `seg_absent_i`, `prot_i` and `page_i` raise vectors 6, 11, 13 and 14. Vectors 11, 13 and 14 carry `flt_err_i` as the error code; vector 6 has no code.
- R6: Vector 17 is raised for a memory access (`mem_i`) only when all of the following hold: `cpl_i`=3, `pe_i`=1, and the alignment enable is set. The access must also be misaligned for its `size_i`, where 1 means 2 bytes with an odd address, 2 means 4 bytes with address mod 4 not 0, and 3 means 8 bytes with address mod 8 not 0. A size of 0 (1 byte) never faults. The vector carries error code 0. The enable is cleared by reset and is loaded from `ac_val_i` on a cycle with `ac_wr_i`.
- R7: When several conditions are true in one cycle, only the lowest vector number is reported.
- R8: `exc_valid_o`, `exc_vec_o` and `exc_err_o` hold stable until `ack_i`. Faults presented while a request is pending are ignored.
- R9: A fault presented after `ack_i` and before `done_i` reports vector 8 with error code 0 and `exc_has_err_o`=1.
- R10: A fault presented after a double fault has been acknowledged and before `done_i` sets `shutdown_o` and raises no vector. `shutdown_o` stays set until reset. `done_i` after a double fault returns the unit to normal reporting.
- R11: `exc_vec_o` never shows 2 while `exc_valid_o` is high.
- R12: After reset, `exc_valid_o` and `shutdown_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_vld_i | input | 1 | An instruction's conditions are presented this cycle |
| div_zero_i | input | 1 | Divisor is zero |
| div_ovf_i | input | 1 | Quotient does not fit the destination |
| into_i | input | 1 | Overflow trap instruction executes |
| of_flag_i | input | 1 | Overflow flag |
| bound_i | input | 1 | Bounds check instruction executes |
| bound_idx_i | input | DW | Signed array index |
| bound_lo_i | input | DW | Signed lower limit |
| bound_hi_i | input | DW | Signed upper limit |
| fp_op_i | input | 1 | Floating-point operation |
| fp_emul_i | input | 1 | Coprocessor emulation bit |
| fpu_present_i | input | 1 | Coprocessor present |
| stk_lim_i | input | 1 | Stack-limit violation |
| bad_op_i | input | 1 | Undefined opcode fault pin |
| seg_absent_i | input | 1 | Segment-not-present fault pin |
| prot_i | input | 1 | Protection fault pin |
| page_i | input | 1 | Page fault pin |
| flt_err_i | input | ERR_W | Error code for the fault pins |
| cpl_i | input | 2 | Current privilege ring |
| pe_i | input | 1 | Protected mode |
| ac_wr_i | input | 1 | Load alignment enable |
| ac_val_i | input | 1 | Alignment enable value |
| mem_i | input | 1 | Instruction accesses memory |
| size_i | input | 2 | Operand size code |
| addr_i | input | AW | Operand address |
| ack_i | input | 1 | Handler accepts the request |
| done_i | input | 1 | Handler completed |
| exc_valid_o | output | 1 | Exception request pending |
| exc_vec_o | output | 8 | Vector number |
| exc_err_o | output | ERR_W | Error code |
| exc_has_err_o | output | 1 | Error code is meaningful |
| shutdown_o | output | 1 | Fault during double-fault delivery |

## Verification
The bench builds the unit with DW=8, AW=12 and ERR_W=16. The 8-bit signed bound operands let negative indices and limits be written as short literals, which puts the bounds check at and across both limits on the negative side within reach. The 12-bit address keeps alignment cases legible while the full mask still covers every address bit. The 16-bit error code lets distinct codes on the pass-through faults show that the right one is routed.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSRC = 10;

  localparam logic [7:0] VEC_DIV    = 8'd0;
  localparam logic [7:0] VEC_NMI    = 8'd2;
  localparam logic [7:0] VEC_OVF    = 8'd4;
  localparam logic [7:0] VEC_BOUND  = 8'd5;
  localparam logic [7:0] VEC_BADOP  = 8'd6;
  localparam logic [7:0] VEC_NOFPU  = 8'd7;
  localparam logic [7:0] VEC_DBL    = 8'd8;
  localparam logic [7:0] VEC_ABSENT = 8'd11;
  localparam logic [7:0] VEC_STACK  = 8'd12;
  localparam logic [7:0] VEC_PROT   = 8'd13;
  localparam logic [7:0] VEC_PAGE   = 8'd14;
  localparam logic [7:0] VEC_ALIGN  = 8'd17;

  // source index order equals ascending vector order
  typedef enum logic [3:0] {
    S_DIV, S_OVF, S_BOUND, S_BADOP, S_NOFPU,
    S_ABSENT, S_STACK, S_PROT, S_PAGE, S_ALIGN
  } src_e;

  typedef enum logic [1:0] {SZ_1 = 2'd0, SZ_2 = 2'd1, SZ_4 = 2'd2, SZ_8 = 2'd3} opsz_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RUN, ST_DREQ, ST_DRUN, ST_SHUT
  } dst_e;

  function automatic logic [7:0] src_vec(input int i);
    case (i)
      S_DIV:    return VEC_DIV;
      S_OVF:    return VEC_OVF;
      S_BOUND:  return VEC_BOUND;
      S_BADOP:  return VEC_BADOP;
      S_NOFPU:  return VEC_NOFPU;
      S_ABSENT: return VEC_ABSENT;
      S_STACK:  return VEC_STACK;
      S_PROT:   return VEC_PROT;
      S_PAGE:   return VEC_PAGE;
      default:  return VEC_ALIGN;
    endcase
  endfunction

  function automatic logic src_has_err(input int i);
    return (i == S_ABSENT) || (i == S_STACK) || (i == S_PROT) ||
           (i == S_PAGE) || (i == S_ALIGN);
  endfunction

  function automatic logic src_ext_err(input int i);
    return (i == S_ABSENT) || (i == S_PROT) || (i == S_PAGE);
  endfunction
endpackage

// File: rtl/exc_align.sv
module exc_align #(
  parameter int AW = 32
) (
  input  logic          ac_en_i,
  input  logic          pe_i,
  input  logic [1:0]    cpl_i,
  input  logic          mem_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  import exc_pkg::*;

  logic [2:0]    low_mask;
  logic [AW-1:0] mask;
  logic          armed;

  always_comb begin
    case (opsz_e'(size_i))
      SZ_2:    low_mask = 3'b001;
      SZ_4:    low_mask = 3'b011;
      SZ_8:    low_mask = 3'b111;
      default: low_mask = 3'b000;
    endcase
  end

  assign mask  = AW'(low_mask);
  assign armed = ac_en_i && pe_i && (cpl_i == 2'd3) && mem_i;
  assign hit_o = armed && (|(addr_i & mask));
endmodule

// File: rtl/exc_detect.sv
module exc_detect #(
  parameter int DW = 32
) (
  input  logic                     vld_i,
  input  logic                     div_zero_i,
  input  logic                     div_ovf_i,
  input  logic                     into_i,
  input  logic                     of_flag_i,
  input  logic                     bound_i,
  input  logic [DW-1:0]            bound_idx_i,
  input  logic [DW-1:0]            bound_lo_i,
  input  logic [DW-1:0]            bound_hi_i,
  input  logic                     fp_op_i,
  input  logic                     fp_emul_i,
  input  logic                     fpu_present_i,
  input  logic                     stk_lim_i,
  input  logic                     bad_op_i,
  input  logic                     seg_absent_i,
  input  logic                     prot_i,
  input  logic                     page_i,
  input  logic                     align_hit_i,
  output logic [exc_pkg::NSRC-1:0] src_o
);
  import exc_pkg::*;

  logic out_lo, out_hi;
  logic [NSRC-1:0] raw;

  assign out_lo = $signed(bound_idx_i) < $signed(bound_lo_i);
  assign out_hi = $signed(bound_idx_i) > $signed(bound_hi_i);

  always_comb begin
    raw           = '0;
    raw[S_DIV]    = div_zero_i || div_ovf_i;
    raw[S_OVF]    = into_i && of_flag_i;
    raw[S_BOUND]  = bound_i && (out_lo || out_hi);
    raw[S_BADOP]  = bad_op_i;
    raw[S_NOFPU]  = fp_op_i && fp_emul_i && !fpu_present_i;
    raw[S_ABSENT] = seg_absent_i;
    raw[S_STACK]  = stk_lim_i;
    raw[S_PROT]   = prot_i;
    raw[S_PAGE]   = page_i;
    raw[S_ALIGN]  = align_hit_i;
  end

  assign src_o = vld_i ? raw : '0;
endmodule

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int N = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign gnt_o[g]    = req_i[g] && !seen[g];
    assign seen[g + 1] = seen[g] || req_i[g];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (gnt_o[i]) idx_o = idx_o | IW'(i);
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_vld_i,
  input  logic             div_zero_i,
  input  logic             div_ovf_i,
  input  logic             into_i,
  input  logic             of_flag_i,
  input  logic             bound_i,
  input  logic [DW-1:0]    bound_idx_i,
  input  logic [DW-1:0]    bound_lo_i,
  input  logic [DW-1:0]    bound_hi_i,
  input  logic             fp_op_i,
  input  logic             fp_emul_i,
  input  logic             fpu_present_i,
  input  logic             stk_lim_i,
  input  logic             bad_op_i,
  input  logic             seg_absent_i,
  input  logic             prot_i,
  input  logic             page_i,
  input  logic [ERR_W-1:0] flt_err_i,
  input  logic [1:0]       cpl_i,
  input  logic             pe_i,
  input  logic             ac_wr_i,
  input  logic             ac_val_i,
  input  logic             mem_i,
  input  logic [1:0]       size_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             ack_i,
  input  logic             done_i,
  output logic             exc_valid_o,
  output logic [7:0]       exc_vec_o,
  output logic [ERR_W-1:0] exc_err_o,
  output logic             exc_has_err_o,
  output logic             shutdown_o
);
  import exc_pkg::*;

  localparam int IW = $clog2(NSRC);

  logic            ac_en_q;
  logic            align_hit;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] gnt;
  logic [IW-1:0]   gnt_idx;
  logic            fault;
  logic [7:0]      sel_vec;
  logic [ERR_W-1:0] sel_err;
  logic            sel_has;
  dst_e            st_q, st_d;
  logic [7:0]      vec_q;
  logic [ERR_W-1:0] err_q;
  logic            has_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ac_en_q <= 1'b0;
    else if (ac_wr_i) ac_en_q <= ac_val_i;
  end

  exc_align #(.AW(AW)) u_align (
    .ac_en_i (ac_en_q),
    .pe_i    (pe_i),
    .cpl_i   (cpl_i),
    .mem_i   (mem_i),
    .size_i  (size_i),
    .addr_i  (addr_i),
    .hit_o   (align_hit)
  );

  exc_detect #(.DW(DW)) u_detect (
    .vld_i         (instr_vld_i),
    .div_zero_i    (div_zero_i),
    .div_ovf_i     (div_ovf_i),
    .into_i        (into_i),
    .of_flag_i     (of_flag_i),
    .bound_i       (bound_i),
    .bound_idx_i   (bound_idx_i),
    .bound_lo_i    (bound_lo_i),
    .bound_hi_i    (bound_hi_i),
    .fp_op_i       (fp_op_i),
    .fp_emul_i     (fp_emul_i),
    .fpu_present_i (fpu_present_i),
    .stk_lim_i     (stk_lim_i),
    .bad_op_i      (bad_op_i),
    .seg_absent_i  (seg_absent_i),
    .prot_i        (prot_i),
    .page_i        (page_i),
    .align_hit_i   (align_hit),
    .src_o         (src)
  );

  exc_prio #(.N(NSRC)) u_prio (
    .req_i (src),
    .gnt_o (gnt),
    .idx_o (gnt_idx),
    .any_o (fault)
  );

  always_comb begin
    sel_vec = src_vec(int'(gnt_idx));
    sel_has = src_has_err(int'(gnt_idx));
    sel_err = src_ext_err(int'(gnt_idx)) ? flt_err_i : '0;
  end

  // delivery tracking
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (fault) st_d = ST_REQ;
      ST_REQ:  if (ack_i) st_d = ST_RUN;
      ST_RUN:  if (fault) st_d = ST_DREQ;
               else if (done_i) st_d = ST_IDLE;
      ST_DREQ: if (ack_i) st_d = ST_DRUN;
      ST_DRUN: if (fault) st_d = ST_SHUT;
               else if (done_i) st_d = ST_IDLE;
      default: st_d = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      vec_q <= '0;
      err_q <= '0;
      has_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && fault) begin
        vec_q <= sel_vec;
        err_q <= sel_err;
        has_q <= sel_has;
      end else if (st_q == ST_RUN && fault) begin
        vec_q <= VEC_DBL;
        err_q <= '0;
        has_q <= 1'b1;
      end
    end
  end

  assign exc_valid_o   = (st_q == ST_REQ) || (st_q == ST_DREQ);
  assign exc_vec_o     = vec_q;
  assign exc_err_o     = err_q;
  assign exc_has_err_o = has_q;
  assign shutdown_o    = (st_q == ST_SHUT);
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
  parameter int ERR_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ack_i,
  input logic [1:0]               cpl_i,
  input logic                     pe_i,
  input logic [exc_pkg::NSRC-1:0] gnt,
  input logic                     exc_valid_o,
  input logic [7:0]               exc_vec_o,
  input logic [ERR_W-1:0]         exc_err_o,
  input logic                     exc_has_err_o,
  input logic                     shutdown_o
);
  a_r7_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o && !ack_i |=> exc_valid_o && $stable(exc_vec_o) && $stable(exc_err_o));

  a_r9_dbl_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o && exc_vec_o == 8'd8 |-> exc_has_err_o && exc_err_o == '0);

  a_r10_shut_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);

  a_r10_shut_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !exc_valid_o);

  a_r11_no_nmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> exc_vec_o != 8'd2);

  a_r6_ring3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o && !$past(exc_valid_o) && exc_vec_o == 8'd17 |->
      $past(cpl_i) == 2'd3 && $past(pe_i));
endmodule

bind exc_unit exc_unit_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ack_i         (ack_i),
  .cpl_i         (cpl_i),
  .pe_i          (pe_i),
  .gnt           (gnt),
  .exc_valid_o   (exc_valid_o),
  .exc_vec_o     (exc_vec_o),
  .exc_err_o     (exc_err_o),
  .exc_has_err_o (exc_has_err_o),
  .shutdown_o    (shutdown_o)
);

// File: tb/sim_exc_unit.sv
`timescale 1ns/1ps
module sim_exc_unit;
  localparam int DW = 8, AW = 12, EW = 16;

  localparam logic [14:0] C_DZ = 15'h0001, C_DO = 15'h0002, C_INTO = 15'h0004,
    C_OF = 15'h0008, C_BND = 15'h0010, C_FP = 15'h0020, C_EMU = 15'h0040,
    C_COP = 15'h0080, C_STK = 15'h0100, C_UD = 15'h0200, C_NP = 15'h0400,
    C_GP = 15'h0800, C_PF = 15'h1000, C_PE = 15'h2000, C_MEM = 15'h4000;

  typedef struct packed {
    logic [3:0]  req;
    logic [14:0] ctl;
    logic [7:0]  idx, lo, hi;
    logic [1:0]  cpl, size;
    logic [11:0] addr;
    logic [15:0] err;
    logic        ev;
    logic [7:0]  evec;
    logic        ehas;
    logic [15:0] eerr;
  } row_t;

  localparam int NROW = 26;
  localparam row_t TBL [NROW] = '{
    '{4'd1, C_DZ, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b1, 8'd0, 1'b0, 16'h0},            // R1
    '{4'd1, C_DO, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b1, 8'd0, 1'b0, 16'h0},            // R1
    '{4'd2, C_INTO|C_OF, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b1, 8'd4, 1'b0, 16'h0},     // R2
    '{4'd2, C_INTO, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},          // R2
    '{4'd3, C_BND, 8'hFB, 8'hFC, 8'd10, 2'd0, 2'd0, 12'h0, 16'h0, 1'b1, 8'd5, 1'b0, 16'h0},        // R3 -5 < -4
    '{4'd3, C_BND, 8'd11, 8'hFC, 8'd10, 2'd0, 2'd0, 12'h0, 16'h0, 1'b1, 8'd5, 1'b0, 16'h0},        // R3
    '{4'd3, C_BND, 8'd10, 8'hFC, 8'd10, 2'd0, 2'd0, 12'h0, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},        // R3 at hi
    '{4'd3, C_BND, 8'hFC, 8'hFC, 8'd10, 2'd0, 2'd0, 12'h0, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},        // R3 at lo
    '{4'd4, C_FP|C_EMU, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b1, 8'd7, 1'b0, 16'h0},      // R4
    '{4'd4, C_FP|C_EMU|C_COP, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},// R4
    '{4'd4, C_FP, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},            // R4
    '{4'd5, C_STK, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'hBEEF, 1'b1, 8'd12, 1'b1, 16'h0},       // R5
    '{4'd5, C_GP, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h1234, 1'b1, 8'd13, 1'b1, 16'h1234},     // R5
    '{4'd5, C_PF, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0006, 1'b1, 8'd14, 1'b1, 16'h0006},     // R5
    '{4'd5, C_NP, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0020, 1'b1, 8'd11, 1'b1, 16'h0020},     // R5
    '{4'd5, C_UD, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h5555, 1'b1, 8'd6, 1'b0, 16'h0},         // R5
    '{4'd6, C_PE|C_MEM, 8'd0, 8'd0, 8'd0, 2'd3, 2'd2, 12'h102, 16'h0, 1'b1, 8'd17, 1'b1, 16'h0},   // R6
    '{4'd6, C_PE|C_MEM, 8'd0, 8'd0, 8'd0, 2'd3, 2'd1, 12'h101, 16'h0, 1'b1, 8'd17, 1'b1, 16'h0},   // R6
    '{4'd6, C_PE|C_MEM, 8'd0, 8'd0, 8'd0, 2'd3, 2'd3, 12'h104, 16'h0, 1'b1, 8'd17, 1'b1, 16'h0},   // R6
    '{4'd6, C_PE|C_MEM, 8'd0, 8'd0, 8'd0, 2'd3, 2'd3, 12'h108, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},    // R6
    '{4'd6, C_PE|C_MEM, 8'd0, 8'd0, 8'd0, 2'd2, 2'd2, 12'h102, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},    // R6
    '{4'd6, C_MEM, 8'd0, 8'd0, 8'd0, 2'd3, 2'd2, 12'h102, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},         // R6
    '{4'd6, C_PE|C_MEM, 8'd0, 8'd0, 8'd0, 2'd3, 2'd0, 12'h103, 16'h0, 1'b0, 8'd0, 1'b0, 16'h0},    // R6
    '{4'd7, C_PF|C_DZ, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0077, 1'b1, 8'd0, 1'b0, 16'h0},    // R7
    '{4'd7, C_STK|C_GP|C_PE|C_MEM, 8'd0, 8'd0, 8'd0, 2'd3, 2'd1, 12'h1, 16'h0099, 1'b1, 8'd12, 1'b1, 16'h0}, // R7
    '{4'd7, C_INTO|C_OF|C_UD, 8'd0, 8'd0, 8'd0, 2'd0, 2'd0, 12'h0, 16'h0, 1'b1, 8'd4, 1'b0, 16'h0}  // R7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld, dz, dov, into, of, bnd, fp, emu, cop, stk, ud, np, gp, pf, pe, acw, acv, mem, ack, done;
  logic [DW-1:0] idx, lo, hi;
  logic [EW-1:0] ferr;
  logic [1:0] cpl, size;
  logic [AW-1:0] addr;
  logic exc_valid, has_err, shut;
  logic [7:0] vec;
  logic [EW-1:0] err;

  int checks = 0, errors = 0, nmi_seen = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  exc_unit #(.DW(DW), .AW(AW), .ERR_W(EW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_vld_i(vld), .div_zero_i(dz), .div_ovf_i(dov),
    .into_i(into), .of_flag_i(of), .bound_i(bnd), .bound_idx_i(idx), .bound_lo_i(lo),
    .bound_hi_i(hi), .fp_op_i(fp), .fp_emul_i(emu), .fpu_present_i(cop), .stk_lim_i(stk),
    .bad_op_i(ud), .seg_absent_i(np), .prot_i(gp), .page_i(pf), .flt_err_i(ferr),
    .cpl_i(cpl), .pe_i(pe), .ac_wr_i(acw), .ac_val_i(acv), .mem_i(mem), .size_i(size),
    .addr_i(addr), .ack_i(ack), .done_i(done), .exc_valid_o(exc_valid), .exc_vec_o(vec),
    .exc_err_o(err), .exc_has_err_o(has_err), .shutdown_o(shut)
  );

  // R11 monitor
  always @(negedge clk) if (rst_n && exc_valid && vec == 8'd2) nmi_seen++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_in();
    {vld, dz, dov, into, of, bnd, fp, emu, cop, stk, ud, np, gp, pf, pe, acw, acv, mem, ack, done} = '0;
    idx = '0; lo = '0; hi = '0; ferr = '0; cpl = '0; size = '0; addr = '0;
  endtask

  task automatic drive(input row_t r);
    clear_in();
    vld = 1'b1;
    {mem, pe, pf, gp, np, ud, stk, cop, emu, fp, bnd, of, into, dov, dz} = r.ctl;
    idx = r.idx; lo = r.lo; hi = r.hi; cpl = r.cpl; size = r.size;
    addr = r.addr; ferr = r.err;
  endtask

  task automatic retire();
    if (exc_valid) begin
      ack = 1'b1; step(); ack = 1'b0;
      done = 1'b1; step(); done = 1'b0;
    end
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
  endtask

  initial begin
    clear_in();
    do_reset();
    check("R12 valid after reset", exc_valid, 0);
    check("R12 shutdown after reset", shut, 0);

    // R6: enable is off after reset
    clear_in(); vld = 1; mem = 1; pe = 1; cpl = 2'd3; size = 2'd1; addr = 12'h001;
    step(); clear_in();
    check("R6 align off after reset", exc_valid, 0);
    retire();

    acw = 1; acv = 1; step(); acw = 0;

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i]); step(); clear_in();
      checks++;
      if (exc_valid !== TBL[i].ev ||
          (TBL[i].ev && (vec !== TBL[i].evec || has_err !== TBL[i].ehas || err !== TBL[i].eerr))) begin
        errors++;
        $display("FAIL R%0d row %0d act=%b/%0d/%b/%0h exp=%b/%0d/%b/%0h", TBL[i].req, i,
                 exc_valid, vec, has_err, err, TBL[i].ev, TBL[i].evec, TBL[i].ehas, TBL[i].eerr);
      end
      retire();
    end

    // R8: hold until ack, ignore faults while pending
    clear_in(); vld = 1; dz = 1; step(); clear_in();
    for (int k = 0; k < 3; k++) begin
      vld = 1; gp = 1; ferr = 16'h00AA; step(); clear_in();
      check("R8 held valid", exc_valid, 1);
      check("R8 held vec", vec, 0);
      check("R8 held err", err, 0);
    end
    ack = 1; step(); ack = 0;
    check("R8 cleared by ack", exc_valid, 0);

    // R9: fault during delivery -> double fault
    vld = 1; stk = 1; step(); clear_in();
    check("R9 dbl valid", exc_valid, 1);
    check("R9 dbl vec", vec, 8);
    check("R9 dbl err", {has_err, err}, {1'b1, 16'h0});
    ack = 1; step(); ack = 0;

    // R10: fault during double-fault delivery -> shutdown
    vld = 1; ud = 1; step(); clear_in();
    check("R10 shutdown set", shut, 1);
    check("R10 no vector", exc_valid, 0);
    done = 1; step(); done = 0;
    vld = 1; dz = 1; step(); clear_in();
    check("R10 shutdown sticky", shut, 1);
    check("R10 still no vector", exc_valid, 0);

    // R10: done after double fault returns to normal reporting
    do_reset();
    check("R12 shutdown cleared by reset", shut, 0);
    vld = 1; dz = 1; step(); clear_in(); ack = 1; step(); ack = 0;
    vld = 1; ud = 1; step(); clear_in();
    check("R9 dbl from bad opcode", vec, 8);
    ack = 1; step(); ack = 0; done = 1; step(); done = 0;
    check("R10 idle after dbl done", {shut, exc_valid}, 0);
    vld = 1; ud = 1; step(); clear_in();
    check("R10 normal vector after dbl done", {exc_valid, vec}, {1'b1, 8'd6});
    retire();

    // R2: idle instruction strobe low gives nothing
    into = 1; of = 1; step(); clear_in();
    check("R2 no strobe no trap", exc_valid, 0);

    check("R11 vector 2 never seen", nmi_seen, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule